// File: doc/BRIEF.md
# Multi-Channel Prescaled Tick Timer

A bank of four independent 32-bit up-counting timers. All four share one prescaler, which divides the system clock into a common tick. On each tick, every enabled channel compares its counter with its own compare value. A match raises a sticky status flag, and that flag drives the channel's interrupt line when interrupts are enabled for the channel. A channel may also clear its counter on a match, which turns it into a periodic interrupt source. When that option is off, the counter runs freely and wraps around.

Software reaches the block through a synchronous register port. The port accepts a request, a write flag, a byte address, 32-bit write data and byte enables. Read data appears one cycle after the request. A write changes state only when all four byte lanes are enabled. A read always returns the whole word, and the requester picks out any byte lane it needs.

Top module: `tick_timer_bank`

## Requirements
- R1: Each of the four channels has a 32-bit counter. It increments by one on a tick while the channel is enabled, and otherwise holds its value.
- R2: At a tick, if an enabled channel's counter equals its compare value, that is a compare event. The event sets the channel's sticky compare status, control bit 3.
- R3: If clear-on-compare (control bit 1) is set, a compare event sets the counter to 0 instead of incrementing it.
- R4: The reload register at address 0x00 holds a value N. One tick occurs every N+1 clocks. A reload of 0 gives a tick on every clock. A newly written value takes effect once the current period ends. The first tick comes on the first clock after reset.
- R5: A write with byte enables other than 4'hF has no effect. A read returns the whole 32-bit word, whatever the byte enables, in the cycle after the request.
- R6: The control word is laid out as follows: bit 0 enable, bit 1 clear-on-compare, bit 2 interrupt enable, bit 3 compare status, bit 4 wrap status. Writing 1 to a status bit clears it. If an event sets the bit in the same cycle, the set wins. Bits 31:5 read as 0.
- R7: irq_o[c] is high exactly while channel c has both its compare status and its interrupt enable set.
- R8: A write to a counter loads the new value directly. The write wins over a tick in the same cycle, and counting resumes from the loaded value at the next tick.
- R9: When a counter at 0xFFFFFFFF increments, it wraps to 0 and sets the wrap status, bit 4.
- R10: Channel c (0..3) occupies the base address 0x10*(c+1). Its control register is at +0x0, its compare register at +0x4 and its counter at +0x8. Any other address reads 0 and ignores writes.
- R11: After reset, all registers read 0 and every irq_o bit is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access request |
| we_i | input | 1 | 1 for write, 0 for read |
| addr_i | input | 7 | Byte address |
| wdata_i | input | 32 | Write data |
| be_i | input | 4 | Byte enables |
| rdata_o | output | 32 | Read data, valid in the cycle after a read request |
| irq_o | output | 4 | Interrupt line for each channel |

## Verification
The bench goes after six corner cases.

- A reload of zero against nonzero reloads. A design off by one in the prescaler ticks at the wrong rate, and every counter read then drifts.
- A counter at 0xFFFFFFFF. A wrong design saturates there or skips the wrap flag.
- Clear-on-compare against free running. A wrong design keeps counting past the match, or clears the counter when the mode is off.
- A write-one-to-clear landing in the same cycle as a new event. A wrong design loses the event.
- A counter load that collides with a tick. A wrong design adds one to the loaded value.
- Partial byte-enable writes. A wrong design alters a register through a narrow write.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;
  localparam int unsigned CTRL_EN  = 0;
  localparam int unsigned CTRL_COC = 1;
  localparam int unsigned CTRL_IE  = 2;
  localparam int unsigned CTRL_STS = 3;
  localparam int unsigned CTRL_WRP = 4;
  localparam int unsigned CTRL_W   = 5;

  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_CMP  = 2'd1,
    SEL_CNT  = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/tick_prescaler.sv
module tick_prescaler #(
  parameter int unsigned PRE_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             reload_we_i,
  input  logic [PRE_W-1:0] reload_i,
  output logic [PRE_W-1:0] reload_o,
  output logic             tick_o
);
  logic [PRE_W-1:0] reload_q;
  logic [PRE_W-1:0] cnt_q;

  assign tick_o   = (cnt_q == '0);
  assign reload_o = reload_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      reload_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (reload_we_i) reload_q <= reload_i;
      // old reload applies to the period that starts now
      cnt_q <= tick_o ? reload_q : cnt_q - 1'b1;
    end
  end

  AST_TICK_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && reload_q != '0) |=> !tick_o); // R4
endmodule

// File: rtl/tick_channel.sv
module tick_channel
  import tick_timer_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              ctrl_we_i,
  input  logic              cmp_we_i,
  input  logic              cnt_we_i,
  input  logic [CNT_W-1:0]  wdata_i,
  output logic [CTRL_W-1:0] ctrl_o,
  output logic [CNT_W-1:0]  cmp_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              irq_o
);
  logic en_q, coc_q, ie_q, sts_q, wrp_q;
  logic [CNT_W-1:0] cmp_q, cnt_q;
  logic run, hit, wrap;

  assign run  = tick_i & en_q;
  assign hit  = run & (cnt_q == cmp_q);
  assign wrap = run & ~(hit & coc_q) & (cnt_q == '1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (cnt_we_i) begin
      cnt_q <= wdata_i;
    end else if (hit && coc_q) begin
      cnt_q <= '0;
    end else if (run) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= 1'b0;
      coc_q <= 1'b0;
      ie_q  <= 1'b0;
      sts_q <= 1'b0;
      wrp_q <= 1'b0;
      cmp_q <= '0;
    end else begin
      if (ctrl_we_i) begin
        en_q  <= wdata_i[CTRL_EN];
        coc_q <= wdata_i[CTRL_COC];
        ie_q  <= wdata_i[CTRL_IE];
      end
      // event set wins over write-one-to-clear
      sts_q <= hit  | (sts_q & ~(ctrl_we_i & wdata_i[CTRL_STS]));
      wrp_q <= wrap | (wrp_q & ~(ctrl_we_i & wdata_i[CTRL_WRP]));
      if (cmp_we_i) cmp_q <= wdata_i;
    end
  end

  assign ctrl_o = {wrp_q, sts_q, ie_q, coc_q, en_q};
  assign cmp_o  = cmp_q;
  assign cnt_o  = cnt_q;
  assign irq_o  = sts_q & ie_q;

  AST_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run && !cnt_we_i) |=> $stable(cnt_q)); // R1
  AST_STS_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit |=> sts_q); // R2
  AST_COC_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit && coc_q && !cnt_we_i) |=> (cnt_q == '0)); // R3
  AST_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wrap && !cnt_we_i) |=> (cnt_q == '0 && wrp_q)); // R9
  AST_IRQ_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !ctrl_we_i) |=> irq_o); // R7
endmodule

// File: rtl/tick_timer_bank.sv
module tick_timer_bank
  import tick_timer_pkg::*;
#(
  parameter int unsigned N_CH   = 4,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W/8-1:0] be_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [N_CH-1:0]   irq_o
);
  localparam int unsigned GRP_W = ADDR_W - 4;

  logic [GRP_W-1:0] grp;
  reg_sel_e         sel;
  logic             wr_ok, pre_we, tick;
  logic [DATA_W-1:0] reload;
  logic [N_CH-1:0]  ctrl_we, cmp_we, cnt_we;
  logic [CTRL_W-1:0] ctrl_v [N_CH];
  logic [DATA_W-1:0] cmp_v  [N_CH];
  logic [DATA_W-1:0] cnt_v  [N_CH];
  logic [DATA_W-1:0] rd_mux, rdata_q;

  assign grp    = addr_i[ADDR_W-1:4];
  assign sel    = reg_sel_e'(addr_i[3:2]);
  assign wr_ok  = req_i & we_i & (be_i == '1);
  assign pre_we = wr_ok & (grp == '0) & (sel == SEL_CTRL);

  tick_prescaler #(.PRE_W(DATA_W)) i_pre (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .reload_we_i (pre_we),
    .reload_i    (wdata_i),
    .reload_o    (reload),
    .tick_o      (tick)
  );

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    logic sel_ch;
    assign sel_ch     = (grp == GRP_W'(c + 1));
    assign ctrl_we[c] = wr_ok & sel_ch & (sel == SEL_CTRL);
    assign cmp_we[c]  = wr_ok & sel_ch & (sel == SEL_CMP);
    assign cnt_we[c]  = wr_ok & sel_ch & (sel == SEL_CNT);

    tick_channel #(.CNT_W(DATA_W)) i_ch (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .tick_i    (tick),
      .ctrl_we_i (ctrl_we[c]),
      .cmp_we_i  (cmp_we[c]),
      .cnt_we_i  (cnt_we[c]),
      .wdata_i   (wdata_i),
      .ctrl_o    (ctrl_v[c]),
      .cmp_o     (cmp_v[c]),
      .cnt_o     (cnt_v[c]),
      .irq_o     (irq_o[c])
    );
  end

  always_comb begin
    rd_mux = '0;
    if (grp == '0 && sel == SEL_CTRL) rd_mux = reload;
    for (int c = 0; c < N_CH; c++) begin
      if (grp == GRP_W'(c + 1)) begin
        unique case (sel)
          SEL_CTRL: rd_mux = DATA_W'(ctrl_v[c]);
          SEL_CMP:  rd_mux = cmp_v[c];
          SEL_CNT:  rd_mux = cnt_v[c];
          default:  rd_mux = '0;
        endcase
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             rdata_q <= '0;
    else if (req_i && !we_i) rdata_q <= rd_mux;
  end
  assign rdata_o = rdata_q;

  AST_NARROW_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && be_i != '1) |-> !(pre_we || |ctrl_we || |cmp_we || |cnt_we)); // R5
  AST_ONE_TARGET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({pre_we, ctrl_we, cmp_we, cnt_we})); // R10
endmodule

// File: tb/test_tick_timer_bank.sv
module test_tick_timer_bank;
  localparam int CLK_P = 10;
  localparam int NCH   = 4;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0, we_i = 1'b0;
  logic [6:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [3:0]  be_i = '0;
  logic [31:0] rdata_o;
  logic [3:0]  irq_o;

  int n_chk = 0, n_err = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  tick_timer_bank i_tick_timer_bank (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .be_i(be_i), .rdata_o(rdata_o), .irq_o(irq_o)
  );

  // reference model
  logic [31:0] m_pre, m_pcnt, exp_rd;
  logic [31:0] m_cnt [NCH], m_cmp [NCH];
  logic        m_en [NCH], m_coc [NCH], m_ie [NCH], m_sts [NCH], m_wrp [NCH];

  function automatic logic [31:0] mread(logic [6:0] a);
    int g = int'(a[6:4]);
    int s = int'(a[3:2]);
    if (g == 0) return (s == 0) ? m_pre : 32'h0;
    if (g > NCH) return 32'h0;
    case (s)
      0: return {27'h0, m_wrp[g-1], m_sts[g-1], m_ie[g-1], m_coc[g-1], m_en[g-1]};
      1: return m_cmp[g-1];
      2: return m_cnt[g-1];
      default: return 32'h0;
    endcase
  endfunction

  function automatic string tag_of(logic [6:0] a);
    int g = int'(a[6:4]);
    int s = int'(a[3:2]);
    if (g == 0 && s == 0) return "R4";
    if (g == 0 || g > NCH || s == 3) return "R10";
    if (s == 0) return "R6";
    if (s == 1) return "R10";
    return "R1";
  endfunction

  task automatic model_reset();
    m_pre = 0; m_pcnt = 0;
    for (int c = 0; c < NCH; c++) begin
      m_cnt[c] = 0; m_cmp[c] = 0; m_en[c] = 0; m_coc[c] = 0;
      m_ie[c] = 0; m_sts[c] = 0; m_wrp[c] = 0;
    end
  endtask

  task automatic model_step(logic rq, logic w, logic [6:0] a, logic [31:0] d, logic [3:0] b);
    logic tick = (m_pcnt == 0);
    logic wok = rq && w && (b == 4'hF);
    int g = int'(a[6:4]);
    int s = int'(a[3:2]);
    if (rq && !w) exp_rd = mread(a);
    for (int c = 0; c < NCH; c++) begin
      logic run = tick && m_en[c];
      logic hit = run && (m_cnt[c] == m_cmp[c]);
      logic wrp = run && !(hit && m_coc[c]) && (m_cnt[c] == 32'hFFFF_FFFF);
      logic sel = wok && (g == c + 1);
      logic [31:0] nc = (hit && m_coc[c]) ? 32'h0 : (run ? m_cnt[c] + 1 : m_cnt[c]);
      m_sts[c] = hit | (m_sts[c] & !(sel && s == 0 && d[3]));
      m_wrp[c] = wrp | (m_wrp[c] & !(sel && s == 0 && d[4]));
      if (sel && s == 0) begin m_en[c] = d[0]; m_coc[c] = d[1]; m_ie[c] = d[2]; end
      if (sel && s == 1) m_cmp[c] = d;
      if (sel && s == 2) nc = d;
      m_cnt[c] = nc;
    end
    m_pcnt = tick ? m_pre : m_pcnt - 1;
    if (wok && g == 0 && s == 0) m_pre = d;
  endtask

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic xact(logic rq, logic w, logic [6:0] a, logic [31:0] d, logic [3:0] b, string tag = "");
    logic [3:0] ei;
    @(negedge clk);
    req_i = rq; we_i = w; addr_i = a; wdata_i = d; be_i = b;
    @(posedge clk);
    model_step(rq, w, a, d, b);
    #(CLK_P/4);
    if (rq && !w) chk((tag == "") ? tag_of(a) : tag, rdata_o, exp_rd);
    for (int c = 0; c < NCH; c++) ei[c] = m_sts[c] & m_ie[c];
    chk("R7", {28'h0, irq_o}, {28'h0, ei});
    req_i = 0;
  endtask

  task automatic wr(logic [6:0] a, logic [31:0] d); xact(1, 1, a, d, 4'hF); endtask
  task automatic rd(logic [6:0] a, string tag = ""); xact(1, 0, a, 32'h0, 4'hF, tag); endtask
  task automatic idle(int n); for (int i = 0; i < n; i++) xact(0, 0, 7'h0, 32'h0, 4'h0); endtask

  function automatic logic [6:0] caddr(int c, int s);
    return 7'((c + 1) * 16 + s * 4);
  endfunction

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    model_reset();
    #(CLK_P * 3);
    @(negedge clk) rst_ni = 1;
    // R11 reset state
    rd(7'h00, "R11");
    for (int c = 0; c < NCH; c++) begin
      rd(caddr(c, 0), "R11"); rd(caddr(c, 1), "R11"); rd(caddr(c, 2), "R11");
    end
    // R4 prescale 3, R3 periodic with irq (R2, R7)
    wr(7'h00, 32'd3);
    wr(caddr(0, 1), 32'd4);
    wr(caddr(0, 0), 32'h7);
    for (int i = 0; i < 40; i++) rd(caddr(0, 2), "R3");
    rd(caddr(0, 0), "R2");
    // R6 W1C
    wr(caddr(0, 0), 32'hF);
    rd(caddr(0, 0), "R6");
    // R9 wrap, prescale 0
    wr(7'h00, 32'd0);
    idle(4);
    wr(caddr(1, 1), 32'd100);
    wr(caddr(1, 2), 32'hFFFF_FFFD);
    wr(caddr(1, 0), 32'h1);
    for (int i = 0; i < 6; i++) rd(caddr(1, 2), "R9");
    rd(caddr(1, 0), "R9");
    // R8 load wins over tick
    wr(caddr(1, 2), 32'h0000_1000);
    rd(caddr(1, 2), "R8");
    rd(caddr(1, 2), "R8");
    // R5 narrow writes ignored, byte-lane reads
    xact(1, 1, caddr(2, 1), 32'hDEAD_BEEF, 4'h1);
    xact(1, 1, caddr(2, 1), 32'hDEAD_BEEF, 4'h7);
    xact(1, 0, caddr(2, 1), 32'h0, 4'h2, "R5");
    xact(1, 1, 7'h00, 32'h55, 4'h3);
    xact(1, 0, 7'h00, 32'h0, 4'h1, "R5");
    // R10 unmapped
    wr(7'h60, 32'hFFFF_FFFF);
    rd(7'h60, "R10");
    rd(caddr(3, 3), "R10");
    // random mix
    for (int i = 0; i < 4000; i++) begin
      int k = int'($urandom_range(0, 9));
      int c = int'($urandom_range(0, NCH - 1));
      int s = int'($urandom_range(0, 3));
      logic [31:0] d = $urandom;
      logic [6:0]  a = ($urandom_range(0, 15) == 0) ? 7'h00 : caddr(c, s);
      if (a == 7'h00) d = 32'($urandom_range(0, 3));
      else if (s == 1) d = 32'($urandom_range(0, 12));
      else if (s == 2 && d[0]) d = 32'hFFFF_FFF0 | 32'($urandom_range(0, 15));
      else if (s == 2) d = 32'($urandom_range(0, 12));
      if (k < 3) xact(1, 1, a, d, (k == 0) ? 4'($urandom) : 4'hF);
      else if (k < 8) xact(1, 0, a, 32'h0, 4'($urandom));
      else idle(1);
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule